// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block follows the host bus strobes of a peripheral channel and decides when the processor is running an interrupt acknowledge cycle. It recognises three ways of signalling that cycle. The first is a status-qualified acknowledge on a multiplexed or a separate address/data bus. The second is one pulse on a dedicated acknowledge pin. The third is a pair of pulses on that pin, in which the first pulse only captures the interrupt state and the second pulse fetches the vector.

From these it produces the timing windows that a neighbouring priority chain and vector driver rely on. These are a one-clock freeze strobe, a level that is high for the whole acknowledge cycle, a window in which the channel may drive its vector, and an active-low wait/ready handshake. All strobe inputs are asynchronous. They pass through a two-stage synchronizer into the block clock before any edge is detected.

The chain-enable and request inputs are synchronous to the block clock. The mode inputs are static while a bus cycle is in progress.

Top module: `iack_seq`

## Requirements
- R1: After reset, freeze, iack_active and iack_read are 0 and wait_rdy_n is 1. A strobe level sampled at clock edge n affects the registered outputs only after edge n+2.
- R2: With muxed_bus=0, a falling stat_ack_n while idle pulses freeze and raises iack_active.
- R3: With muxed_bus=1, an acknowledge starts only on a rising as_n while stat_ack_n is low. Edges of stat_ack_n alone have no effect, and an as_n rise with stat_ack_n high begins an ordinary access.
- R4: In a status acknowledge, the falling rd_n opens iack_read (when responding). The rising rd_n closes iack_read and drops iack_active on the same edge.
- R5: With two_pulse=0, a falling pulse_ack_n while idle pulses freeze and opens iack_read on the same edge. Its rising edge ends the cycle.
- R6: With two_pulse=1, the first falling pulse_ack_n only pulses freeze and raises iack_active. The second falling edge opens iack_read, and the second rising edge ends the cycle. Reset forgets a half-finished pair.
- R7: If chain_en_in or chan_req is low at the edge where the read opens, iack_read and the handshake stay inactive. iack_active still ends with the strobe.
- R8: With wait_mode=1, wait_rdy_n goes low when the vector window opens and returns high VEC_LAT clocks later. It is never low during an ordinary read.
- R9: With wait_mode=0, wait_rdy_n goes low VEC_LAT clocks after the vector window opens and stays low until the window closes. For an ordinary read it goes low on the read-detect edge and stays low until rd_n rises.
- R10: freeze is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_ack_n | input | 1 | Status-qualified acknowledge, active low, asynchronous |
| pulse_ack_n | input | 1 | Pulsed acknowledge, active low, asynchronous |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| muxed_bus | input | 1 | 1 = multiplexed address/data bus |
| two_pulse | input | 1 | 1 = acknowledge uses a pair of pulses |
| wait_mode | input | 1 | 1 = handshake acts as wait, 0 = as ready |
| chain_en_in | input | 1 | Priority chain enable from higher priority |
| chan_req | input | 1 | Channel has an interrupt pending |
| freeze | output | 1 | One-clock strobe capturing interrupt state |
| iack_active | output | 1 | Acknowledge cycle in progress |
| iack_read | output | 1 | Window in which the vector may be driven |
| wait_rdy_n | output | 1 | Wait/ready handshake, active low |

## Verification
The hardest state to reach from the ports is a double-pulse pair that is cut by reset after its first pulse. A later pulse must then act as a first pulse again and must not open the vector window. The stimulus drives one pulse in double mode, asserts reset in the gap, and then drives a full pair. A behavioural model, fed with the same three-clock strobe latency, is compared with all four outputs every clock through this and every other sequence.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REG,
    SQ_ARMED,
    SQ_PFIRST,
    SQ_READ
  } sq_state_t;

  localparam int unsigned STB_STAT  = 0;
  localparam int unsigned STB_PULSE = 1;
  localparam int unsigned STB_AS    = 2;
  localparam int unsigned STB_RD    = 3;
  localparam int unsigned STB_N     = 4;
endpackage

// File: rtl/iack_sync.sv
module iack_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  // Per strobe: STAGES synchronizer flops plus one history flop for edges.
  // Idle level of every strobe is high.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-1:0], din[i]};
    end
    assign lvl[i] = chain[STAGES-1];
    assign prv[i] = chain[STAGES];
  end
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [STB_N-1:0] lvl,
  input  logic [STB_N-1:0] prv,
  input  logic             muxed_bus,
  input  logic             two_pulse,
  input  logic             chain_en_in,
  input  logic             chan_req,
  output logic             freeze,
  output logic             iack_active,
  output logic             iack_read,
  output logic             ack_start,
  output logic             ack_end,
  output logic             ord_start,
  output logic             ord_end
);
  sq_state_t st_q, st_d;
  logic src_q, src_d;        // 1 = cycle read strobe is the pulse pin
  logic freeze_q, active_q, read_q;
  logic frz_ev, rd_start, fin, o_start, o_end;

  logic stat_fall, pulse_fall, pulse_rise, as_rise, rd_fall, rd_rise;
  logic stat_trig, respond;

  assign stat_fall  =  prv[STB_STAT]  & ~lvl[STB_STAT];
  assign pulse_fall =  prv[STB_PULSE] & ~lvl[STB_PULSE];
  assign pulse_rise = ~prv[STB_PULSE] &  lvl[STB_PULSE];
  assign as_rise    = ~prv[STB_AS]    &  lvl[STB_AS];
  assign rd_fall    =  prv[STB_RD]    & ~lvl[STB_RD];
  assign rd_rise    = ~prv[STB_RD]    &  lvl[STB_RD];

  // Multiplexed bus: the status pin behaves like an address bit latched by AS.
  assign stat_trig = muxed_bus ? (as_rise & ~lvl[STB_STAT]) : stat_fall;
  assign respond   = chain_en_in & chan_req;

  always_comb begin
    st_d     = st_q;
    src_d    = src_q;
    frz_ev   = 1'b0;
    rd_start = 1'b0;
    fin      = 1'b0;
    o_start  = 1'b0;
    o_end    = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (stat_trig) begin
          frz_ev = 1'b1;
          st_d   = SQ_ARMED;
          src_d  = 1'b0;
        end else if (pulse_fall) begin
          frz_ev = 1'b1;
          if (two_pulse) begin
            st_d = SQ_PFIRST;
          end else begin
            st_d     = SQ_READ;
            rd_start = 1'b1;
            src_d    = 1'b1;
          end
        end else if (rd_fall) begin
          st_d    = SQ_REG;
          o_start = 1'b1;
        end
      end
      SQ_REG: begin
        if (rd_rise) begin
          st_d  = SQ_IDLE;
          o_end = 1'b1;
        end
      end
      SQ_ARMED: begin
        if (rd_fall) begin
          st_d     = SQ_READ;
          rd_start = 1'b1;
          src_d    = 1'b0;
        end
      end
      SQ_PFIRST: begin
        if (pulse_fall) begin
          st_d     = SQ_READ;
          rd_start = 1'b1;
          src_d    = 1'b1;
        end
      end
      SQ_READ: begin
        if (src_q ? pulse_rise : rd_rise) begin
          st_d = SQ_IDLE;
          fin  = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      src_q    <= 1'b0;
      freeze_q <= 1'b0;
      active_q <= 1'b0;
      read_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      src_q    <= src_d;
      freeze_q <= frz_ev;
      active_q <= (st_d == SQ_ARMED) || (st_d == SQ_PFIRST) || (st_d == SQ_READ);
      if (rd_start)  read_q <= respond;
      else if (fin)  read_q <= 1'b0;
    end
  end

  assign freeze      = freeze_q;
  assign iack_active = active_q;
  assign iack_read   = read_q;
  assign ack_start   = rd_start & respond;
  assign ack_end     = fin;
  assign ord_start   = o_start;
  assign ord_end     = o_end;

  assert_freeze_single_R10: assert property (@(posedge clk) disable iff (rst)
    freeze_q |=> !freeze_q);
  assert_freeze_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    freeze_q |-> $past(st_q == SQ_IDLE));
  assert_window_in_ack_R4: assert property (@(posedge clk) disable iff (rst)
    read_q |-> active_q);
  assert_first_pulse_no_window_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_PFIRST) |-> !read_q);
endmodule

// File: rtl/iack_hs.sv
module iack_hs #(
  parameter int unsigned VEC_LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_mode,
  input  logic in_ack,
  input  logic ack_start,
  input  logic ack_end,
  input  logic ord_start,
  input  logic ord_end,
  output logic hs_n
);
  localparam int unsigned CW = $clog2(VEC_LAT + 1);
  localparam logic [CW-1:0] LAT = CW'(VEC_LAT);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          hs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      hs_n_q <= 1'b1;
    end else if (ack_end || ord_end) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      hs_n_q <= 1'b1;
    end else if (ack_start) begin
      cnt_q  <= CW'(1);
      busy_q <= 1'b1;
      hs_n_q <= !wait_mode;      // wait: assert now; ready: hold off
    end else if (ord_start) begin
      hs_n_q <= wait_mode;       // ready only; wait never asserted
    end else if (busy_q) begin
      if (cnt_q == LAT) hs_n_q <= wait_mode;  // vector valid
      else              cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign hs_n = hs_n_q;

  assert_wait_only_in_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (wait_mode && !hs_n_q) |-> in_ack);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAT);
  assert_ready_late_R9: assert property (@(posedge clk) disable iff (rst)
    (!wait_mode && busy_q && cnt_q < LAT) |-> hs_n_q);
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_LAT     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stat_ack_n,
  input  logic pulse_ack_n,
  input  logic as_n,
  input  logic rd_n,
  input  logic muxed_bus,
  input  logic two_pulse,
  input  logic wait_mode,
  input  logic chain_en_in,
  input  logic chan_req,
  output logic freeze,
  output logic iack_active,
  output logic iack_read,
  output logic wait_rdy_n
);
  logic [STB_N-1:0] raw, lvl, prv;
  logic ack_start, ack_end, ord_start, ord_end;

  always_comb begin
    raw           = '1;
    raw[STB_STAT]  = stat_ack_n;
    raw[STB_PULSE] = pulse_ack_n;
    raw[STB_AS]    = as_n;
    raw[STB_RD]    = rd_n;
  end

  iack_sync #(.W(STB_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .lvl (lvl),
    .prv (prv)
  );

  iack_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .lvl         (lvl),
    .prv         (prv),
    .muxed_bus   (muxed_bus),
    .two_pulse   (two_pulse),
    .chain_en_in (chain_en_in),
    .chan_req    (chan_req),
    .freeze      (freeze),
    .iack_active (iack_active),
    .iack_read   (iack_read),
    .ack_start   (ack_start),
    .ack_end     (ack_end),
    .ord_start   (ord_start),
    .ord_end     (ord_end)
  );

  iack_hs #(.VEC_LAT(VEC_LAT)) u_hs (
    .clk       (clk),
    .rst       (rst),
    .wait_mode (wait_mode),
    .in_ack    (iack_active),
    .ack_start (ack_start),
    .ack_end   (ack_end),
    .ord_start (ord_start),
    .ord_end   (ord_end),
    .hs_n      (wait_rdy_n)
  );
endmodule

// File: tb/iack_seq_test.sv
module iack_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stat_ack_n = 1'b1, pulse_ack_n = 1'b1, as_n = 1'b1, rd_n = 1'b1;
  logic muxed_bus = 1'b0, two_pulse = 1'b0, wait_mode = 1'b1;
  logic chain_en_in = 1'b1, chan_req = 1'b1;
  logic freeze, iack_active, iack_read, wait_rdy_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  iack_seq #(.SYNC_STAGES(2), .VEC_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .stat_ack_n(stat_ack_n), .pulse_ack_n(pulse_ack_n),
    .as_n(as_n), .rd_n(rd_n), .muxed_bus(muxed_bus), .two_pulse(two_pulse),
    .wait_mode(wait_mode), .chain_en_in(chain_en_in), .chan_req(chan_req),
    .freeze(freeze), .iack_active(iack_active), .iack_read(iack_read),
    .wait_rdy_n(wait_rdy_n)
  );

  // Behavioural reference: strobes seen through a fixed 3-clock history.
  logic [3:0] h1 = 4'hF, h2 = 4'hF, h3 = 4'hF;
  int  phase = 0;         // 0 idle, 1 ordinary read, 2 armed, 3 between pulses, 4 vector read
  bit  by_pulse = 0;
  bit  e_frz = 0, e_act = 0, e_rd = 0, e_hs = 1, m_busy = 0;
  int  m_cnt = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    cycles++;
    if (rst) begin
      h1 = 4'hF; h2 = 4'hF; h3 = 4'hF;
      phase = 0; by_pulse = 0;
      e_frz = 0; e_act = 0; e_rd = 0; e_hs = 1; m_busy = 0; m_cnt = 0;
    end else begin
      bit sf, pf, pr, ar, rf, rr, trig, ack_go, ack_done, ord_go, ord_done;
      sf = h3[0] && !h2[0];
      pf = h3[1] && !h2[1];
      pr = !h3[1] && h2[1];
      ar = !h3[2] && h2[2];
      rf = h3[3] && !h2[3];
      rr = !h3[3] && h2[3];
      trig = muxed_bus ? (ar && !h2[0]) : sf;
      ack_go = 0; ack_done = 0; ord_go = 0; ord_done = 0; e_frz = 0;
      if (phase == 0) begin
        if (trig) begin e_frz = 1; phase = 2; by_pulse = 0; end
        else if (pf) begin
          e_frz = 1;
          if (two_pulse) phase = 3;
          else begin phase = 4; by_pulse = 1; ack_go = 1; end
        end else if (rf) begin phase = 1; ord_go = 1; end
      end else if (phase == 1) begin
        if (rr) begin phase = 0; ord_done = 1; end
      end else if (phase == 2) begin
        if (rf) begin phase = 4; by_pulse = 0; ack_go = 1; end
      end else if (phase == 3) begin
        if (pf) begin phase = 4; by_pulse = 1; ack_go = 1; end
      end else begin
        if (by_pulse ? pr : rr) begin phase = 0; ack_done = 1; end
      end
      e_act = (phase >= 2);
      if (ack_go) e_rd = chain_en_in && chan_req;
      else if (ack_done) e_rd = 0;
      if (ack_done || ord_done) begin e_hs = 1; m_busy = 0; m_cnt = 0; end
      else if (ack_go && chain_en_in && chan_req) begin m_busy = 1; m_cnt = 1; e_hs = !wait_mode; end
      else if (ord_go) e_hs = wait_mode;
      else if (m_busy) begin
        if (m_cnt == LAT) e_hs = wait_mode;
        else m_cnt++;
      end
      h3 = h2; h2 = h1; h1 = {rd_n, as_n, pulse_ack_n, stat_ack_n};
    end
  end

  task automatic chk(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("freeze", freeze, e_frz);
      chk("iack_active", iack_active, e_act);
      chk("iack_read", iack_read, e_rd);
      chk("wait_rdy_n", wait_rdy_n, e_hs);
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ord_read();
    rd_n = 1'b0; tick(8); rd_n = 1'b1; tick(5);
  endtask

  task automatic stat_cycle();
    stat_ack_n = 1'b0; tick(4);
    rd_n = 1'b0; tick(10);
    rd_n = 1'b1; tick(3);
    stat_ack_n = 1'b1; tick(5);
  endtask

  task automatic muxed_cycle(bit st);
    as_n = 1'b0; stat_ack_n = st; tick(3);
    as_n = 1'b1; tick(3);
    stat_ack_n = 1'b1; tick(2);
    rd_n = 1'b0; tick(10);
    rd_n = 1'b1; tick(5);
  endtask

  task automatic pulse();
    pulse_ack_n = 1'b0; tick(9); pulse_ack_n = 1'b1; tick(5);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tag = "R1";
    chk("reset freeze", freeze, 1'b0);
    chk("reset active", iack_active, 1'b0);
    chk("reset read", iack_read, 1'b0);
    chk("reset hs", wait_rdy_n, 1'b1);
    tick(2);

    tag = "R8"; wait_mode = 1'b1; ord_read();       // no wait on plain read
    tag = "R2"; stat_cycle();                       // R4 window, R8 wait then release
    tag = "R9"; wait_mode = 1'b0; ord_read();        // early ready for plain read
    tag = "R4"; stat_cycle();                       // late ready in acknowledge

    tag = "R3"; muxed_bus = 1'b1;
    stat_ack_n = 1'b0; tick(6); stat_ack_n = 1'b1; tick(6);  // ignored alone
    muxed_cycle(1'b1);                               // ordinary access
    muxed_cycle(1'b0);                               // acknowledge
    wait_mode = 1'b1; muxed_cycle(1'b0);
    muxed_bus = 1'b0;

    tag = "R7"; chain_en_in = 1'b0; stat_cycle(); chain_en_in = 1'b1;
    chan_req = 1'b0; pulse(); chan_req = 1'b1;

    tag = "R5"; two_pulse = 1'b0; wait_mode = 1'b0; pulse();
    wait_mode = 1'b1; pulse();

    tag = "R6"; two_pulse = 1'b1; pulse(); pulse();
    wait_mode = 1'b0; pulse(); pulse();
    pulse();                                         // half pair, then reset
    rst = 1'b1; tick(2); rst = 1'b0; tick(3);
    pulse(); pulse();

    tag = "R10"; two_pulse = 1'b0; pulse(); stat_cycle();
    tick(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule